// File: doc/BRIEF.md
# Register-Access Tunnel over a Typed Stream Link

This block lets register reads and writes travel across a 32-bit streaming link. Each stream beat carries a two-bit message type in `tuser`. Requests that arrive on the incoming stream are replayed on a local AXI-Lite master port: a write arrives as two beats and a read as one beat. The data of a local read goes back out on the outgoing stream as a typed response beat. In the other direction, a local controller drives an AXI-Lite slave port. Accesses that hit the remote page become outgoing stream requests. A read in that page waits for the matching response beat before it completes.

The slave window also holds a small mailbox of 32-bit words at the lowest offsets. A local write to the mailbox updates the word and sends a copy to the far side as a stream write, so that the far side's copy stays equal. A stream write aimed at the mailbox base address updates the local word and goes no further. Two independent state machines serve the two directions. A small arbiter merges their outgoing beats and never splits a two-beat write.

Top module: `lite_stream_bridge`

## Requirements
- R1: After reset, no valid is asserted on the outgoing stream, the master port or the slave response channels, `s_tready` is high, and every mailbox word reads zero.
- R2: An incoming beat with type 2'b00 is consumed. It causes no master access and no outgoing beat.
- R3: An incoming message of type 2'b01 has two beats. Beat 1 is the address and beat 2 is the data. For an address outside the mailbox page, exactly one master write is made with that address and data. The type of beat 2 is not examined.
- R4: An incoming beat of type 2'b10 carries a read address. One master read is made at that address, and its data leaves as one outgoing beat of type 2'b11.
- R5: A slave write accepted at byte offset 0x000–0x01F stores the word. A slave read at that offset returns the word without any stream traffic.
- R6: A mailbox write sends two beats of type 2'b01: first `MBOX_BASE | offset`, then the data. `slv_bvalid` rises only after the second beat is accepted.
- R7: A slave write in the remote page (offsets 0x1000–0x1FFF by default) sends two beats of type 2'b01: first the zero-extended offset, then the data. It then completes with `slv_bresp` = 2'b00.
- R8: A slave read in the remote page sends one beat of type 2'b10 that carries the zero-extended offset. `slv_rvalid` stays low until an incoming beat of type 2'b11 arrives, and `slv_rdata` then equals that beat's data.
- R9: A slave access outside both the mailbox and the remote page completes with response 2'b00 and causes no stream beat. A read of such an address returns zero.
- R10: An incoming two-beat write whose address lies in `MBOX_BASE`..`MBOX_BASE+0x1F` updates the mailbox word. It makes no master write and sends no outgoing beat.
- R11: An incoming beat of type 2'b11 that arrives while no slave read is waiting is dropped, and `slv_rvalid` stays low.
- R12: The outgoing stream holds a presented beat stable until it is accepted. Once the first beat of a write is accepted, the next accepted beat is that write's data beat, even when a read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tvalid | input | 1 | Incoming stream valid |
| s_tdata | input | 32 | Incoming stream data |
| s_tuser | input | 2 | Incoming message type |
| s_tready | output | 1 | Incoming stream ready |
| m_tvalid | output | 1 | Outgoing stream valid |
| m_tdata | output | 32 | Outgoing stream data |
| m_tuser | output | 2 | Outgoing message type |
| m_tready | input | 1 | Outgoing stream ready |
| mst_awvalid | output | 1 | Master write address valid |
| mst_awaddr | output | 32 | Master write address |
| mst_awready | input | 1 | Master write address ready |
| mst_wvalid | output | 1 | Master write data valid |
| mst_wdata | output | 32 | Master write data |
| mst_wready | input | 1 | Master write data ready |
| mst_bvalid | input | 1 | Master write response valid |
| mst_bready | output | 1 | Master write response ready |
| mst_arvalid | output | 1 | Master read address valid |
| mst_araddr | output | 32 | Master read address |
| mst_arready | input | 1 | Master read address ready |
| mst_rvalid | input | 1 | Master read data valid |
| mst_rdata | input | 32 | Master read data |
| mst_rready | output | 1 | Master read data ready |
| slv_awvalid | input | 1 | Slave write address valid (accepted together with write data) |
| slv_awaddr | input | SLV_AW | Slave write byte offset |
| slv_awready | output | 1 | Slave write address ready |
| slv_wvalid | input | 1 | Slave write data valid |
| slv_wdata | input | 32 | Slave write data |
| slv_wready | output | 1 | Slave write data ready |
| slv_bvalid | output | 1 | Slave write response valid |
| slv_bresp | output | 2 | Slave write response, always 2'b00 |
| slv_bready | input | 1 | Slave write response ready |
| slv_arvalid | input | 1 | Slave read address valid |
| slv_araddr | input | SLV_AW | Slave read byte offset |
| slv_arready | output | 1 | Slave read address ready |
| slv_rvalid | output | 1 | Slave read data valid |
| slv_rdata | output | 32 | Slave read data |
| slv_rresp | output | 2 | Slave read response, always 2'b00 |
| slv_rready | input | 1 | Slave read data ready |

## Verification
The incoming stream is driven with each of the four message types. Writes are sent to an ordinary address and to the mailbox base, and a response beat is sent both while no read is pending and while one is waiting. Together these separate a replayed master access from a mailbox update, a dropped beat and a delivered response. The slave port is exercised at the mailbox, remote and unmapped offsets, so that mirrored writes, forwarded requests and silent completion each show a different outgoing beat count and address. A final pattern stalls the outgoing stream between the two beats of a write while a read response becomes ready, which exposes any interleaving or wrong priority in the arbiter.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    MSG_NONE = 2'b00,
    MSG_WR   = 2'b01,
    MSG_RD   = 2'b10,
    MSG_RSP  = 2'b11
  } msg_t;

  // Address lies in the aligned page of 2**lg bytes that starts at base.
  function automatic logic in_page(input logic [WORD_W-1:0] addr,
                                   input logic [WORD_W-1:0] base,
                                   input int unsigned lg);
    return (addr >> lg) == (base >> lg);
  endfunction

  // Far-side mailbox address for a local mailbox offset.
  function automatic logic [WORD_W-1:0] mbox_far(input logic [WORD_W-1:0] base,
                                                 input logic [WORD_W-1:0] off,
                                                 input int unsigned lg);
    logic [WORD_W-1:0] mask;
    mask = (WORD_W'(1) << lg) - WORD_W'(1);
    return (base & ~mask) | (off & mask);
  endfunction

endpackage

// File: rtl/lsb_mbox.sv
module lsb_mbox #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 8,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [DW-1:0] a_data,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [DW-1:0] b_data,
  input  logic [IW-1:0] r_idx,
  output logic [DW-1:0] r_data
);

  logic [DW-1:0] word_q [WORDS];

  // Port a (local slave) is written last so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) word_q[i] <= '0;
    end else begin
      if (b_we) word_q[b_idx] <= b_data;
      if (a_we) word_q[a_idx] <= a_data;
    end
  end

  assign r_data = word_q[r_idx];

endmodule

// File: rtl/lsb_rx.sv
module lsb_rx
  import lsb_pkg::*;
#(
  parameter int unsigned        MB_LG     = 5,
  parameter logic [WORD_W-1:0]  MBOX_BASE = 32'h0000_2000,
  localparam int unsigned       IW        = MB_LG - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic [WORD_W-1:0] s_tdata,
  input  logic [1:0]        s_tuser,
  output logic              s_tready,
  output logic              mst_awvalid,
  output logic [WORD_W-1:0] mst_awaddr,
  input  logic              mst_awready,
  output logic              mst_wvalid,
  output logic [WORD_W-1:0] mst_wdata,
  input  logic              mst_wready,
  input  logic              mst_bvalid,
  output logic              mst_bready,
  output logic              mst_arvalid,
  output logic [WORD_W-1:0] mst_araddr,
  input  logic              mst_arready,
  input  logic              mst_rvalid,
  input  logic [WORD_W-1:0] mst_rdata,
  output logic              mst_rready,
  output logic              mb_we,
  output logic [IW-1:0]     mb_idx,
  output logic [WORD_W-1:0] mb_data,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data,
  output logic              up_valid,
  output logic [WORD_W-1:0] up_data,
  input  logic              up_ready
);

  typedef enum logic [2:0] {
    RX_IDLE, RX_WDATA, RX_WISSUE, RX_BWAIT, RX_AR, RX_RWAIT, RX_RSEND
  } rx_st_t;

  rx_st_t            st_q;
  logic [WORD_W-1:0] addr_q, data_q;
  logic              aw_done_q, w_done_q;
  logic              acc, hit_mbox, aw_fire, w_fire;

  assign s_tready = (st_q == RX_IDLE) || (st_q == RX_WDATA);
  assign acc      = s_tvalid && s_tready;
  assign hit_mbox = in_page(addr_q, MBOX_BASE, MB_LG);

  assign mst_awvalid = (st_q == RX_WISSUE) && !aw_done_q;
  assign mst_wvalid  = (st_q == RX_WISSUE) && !w_done_q;
  assign mst_awaddr  = addr_q;
  assign mst_wdata   = data_q;
  assign mst_bready  = (st_q == RX_BWAIT);
  assign mst_arvalid = (st_q == RX_AR);
  assign mst_araddr  = addr_q;
  assign mst_rready  = (st_q == RX_RWAIT);
  assign aw_fire     = mst_awvalid && mst_awready;
  assign w_fire      = mst_wvalid && mst_wready;

  assign mb_we    = (st_q == RX_WDATA) && acc && hit_mbox;
  assign mb_idx   = addr_q[MB_LG-1:2];
  assign mb_data  = s_tdata;
  assign rsp_hit  = (st_q == RX_IDLE) && acc && (msg_t'(s_tuser) == MSG_RSP);
  assign rsp_data = s_tdata;
  assign up_valid = (st_q == RX_RSEND);
  assign up_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= RX_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
    end else begin
      unique case (st_q)
        RX_IDLE: if (acc) begin
          unique case (msg_t'(s_tuser))
            MSG_WR:  begin addr_q <= s_tdata; st_q <= RX_WDATA; end
            MSG_RD:  begin addr_q <= s_tdata; st_q <= RX_AR;    end
            default: ;
          endcase
        end
        RX_WDATA: if (acc) begin
          data_q    <= s_tdata;
          aw_done_q <= 1'b0;
          w_done_q  <= 1'b0;
          st_q      <= hit_mbox ? RX_IDLE : RX_WISSUE;
        end
        RX_WISSUE: begin
          if (aw_fire) aw_done_q <= 1'b1;
          if (w_fire)  w_done_q  <= 1'b1;
          if ((aw_done_q || aw_fire) && (w_done_q || w_fire)) st_q <= RX_BWAIT;
        end
        RX_BWAIT: if (mst_bvalid) st_q <= RX_IDLE;
        RX_AR:    if (mst_arready) st_q <= RX_RWAIT;
        RX_RWAIT: if (mst_rvalid) begin data_q <= mst_rdata; st_q <= RX_RSEND; end
        RX_RSEND: if (up_ready) st_q <= RX_IDLE;
        default:  st_q <= RX_IDLE;
      endcase
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mst_awvalid && !mst_awready |=> mst_awvalid && $stable(mst_awaddr)); // R3
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mst_arvalid && !mst_arready |=> mst_arvalid && $stable(mst_araddr)); // R4
  AST_MBOX_NO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    mb_we |=> !mst_awvalid && !mst_wvalid); // R10

endmodule

// File: rtl/lsb_tx.sv
module lsb_tx
  import lsb_pkg::*;
#(
  parameter int unsigned       SLV_AW    = 15,
  parameter int unsigned       MB_LG     = 5,
  parameter logic [WORD_W-1:0] MBOX_BASE = 32'h0000_2000,
  parameter logic [WORD_W-1:0] RMT_BASE  = 32'h0000_1000,
  parameter int unsigned       RMT_LG    = 12,
  localparam int unsigned      IW        = MB_LG - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slv_awvalid,
  input  logic [SLV_AW-1:0] slv_awaddr,
  output logic              slv_awready,
  input  logic              slv_wvalid,
  input  logic [WORD_W-1:0] slv_wdata,
  output logic              slv_wready,
  output logic              slv_bvalid,
  input  logic              slv_bready,
  input  logic              slv_arvalid,
  input  logic [SLV_AW-1:0] slv_araddr,
  output logic              slv_arready,
  output logic              slv_rvalid,
  output logic [WORD_W-1:0] slv_rdata,
  input  logic              slv_rready,
  output logic              mb_we,
  output logic [IW-1:0]     mb_idx,
  output logic [WORD_W-1:0] mb_data,
  output logic [IW-1:0]     mb_ridx,
  input  logic [WORD_W-1:0] mb_rdata,
  input  logic              rsp_hit,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              up_valid,
  output logic [WORD_W-1:0] up_data,
  output logic [1:0]        up_user,
  output logic              up_last,
  input  logic              up_ready
);

  typedef enum logic [2:0] {
    TX_IDLE, TX_SEND_A, TX_SEND_D, TX_BRESP, TX_SEND_R, TX_RWAIT, TX_RRESP
  } tx_st_t;

  tx_st_t            st_q;
  logic [WORD_W-1:0] addr_q, data_q, rdata_q;
  logic [WORD_W-1:0] w_off, r_off;
  logic              wr_go, rd_go, w_mb, w_rm, r_mb, r_rm;

  assign w_off = WORD_W'(slv_awaddr);
  assign r_off = WORD_W'(slv_araddr);
  assign w_mb  = in_page(w_off, '0, MB_LG);
  assign w_rm  = in_page(w_off, RMT_BASE, RMT_LG);
  assign r_mb  = in_page(r_off, '0, MB_LG);
  assign r_rm  = in_page(r_off, RMT_BASE, RMT_LG);

  assign wr_go = (st_q == TX_IDLE) && slv_awvalid && slv_wvalid;
  assign rd_go = (st_q == TX_IDLE) && slv_arvalid && !(slv_awvalid && slv_wvalid);

  assign slv_awready = wr_go;
  assign slv_wready  = wr_go;
  assign slv_arready = rd_go;
  assign slv_bvalid  = (st_q == TX_BRESP);
  assign slv_rvalid  = (st_q == TX_RRESP);
  assign slv_rdata   = rdata_q;

  assign mb_we   = wr_go && w_mb;
  assign mb_idx  = slv_awaddr[MB_LG-1:2];
  assign mb_data = slv_wdata;
  assign mb_ridx = slv_araddr[MB_LG-1:2];

  always_comb begin
    up_valid = 1'b0;
    up_data  = addr_q;
    up_user  = MSG_WR;
    up_last  = 1'b0;
    unique case (st_q)
      TX_SEND_A: up_valid = 1'b1;
      TX_SEND_D: begin up_valid = 1'b1; up_data = data_q; up_last = 1'b1; end
      TX_SEND_R: begin up_valid = 1'b1; up_user = MSG_RD; up_last = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= TX_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: begin
          if (wr_go) begin
            data_q <= slv_wdata;
            addr_q <= w_mb ? mbox_far(MBOX_BASE, w_off, MB_LG) : w_off;
            st_q   <= (w_mb || w_rm) ? TX_SEND_A : TX_BRESP;
          end else if (rd_go) begin
            addr_q <= r_off;
            if (r_rm) st_q <= TX_SEND_R;
            else begin
              rdata_q <= r_mb ? mb_rdata : '0;
              st_q    <= TX_RRESP;
            end
          end
        end
        TX_SEND_A: if (up_ready) st_q <= TX_SEND_D;
        TX_SEND_D: if (up_ready) st_q <= TX_BRESP;
        TX_SEND_R: if (up_ready) st_q <= TX_RWAIT;
        TX_RWAIT:  if (rsp_hit) begin rdata_q <= rsp_data; st_q <= TX_RRESP; end
        TX_BRESP:  if (slv_bready) st_q <= TX_IDLE;
        TX_RRESP:  if (slv_rready) st_q <= TX_IDLE;
        default:   st_q <= TX_IDLE;
      endcase
    end
  end

  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slv_bvalid && !slv_bready |=> slv_bvalid); // R7
  AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rvalid && !slv_rready |=> slv_rvalid && $stable(slv_rdata)); // R8
  AST_BRESP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_user == MSG_WR && !up_last |=> !slv_bvalid); // R6

endmodule

// File: rtl/lsb_up_arb.sv
module lsb_up_arb
  import lsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic [WORD_W-1:0] a_data,
  output logic              a_ready,
  input  logic              b_valid,
  input  logic [WORD_W-1:0] b_data,
  input  logic [1:0]        b_user,
  input  logic              b_last,
  output logic              b_ready,
  output logic              m_tvalid,
  output logic [WORD_W-1:0] m_tdata,
  output logic [1:0]        m_tuser,
  input  logic              m_tready
);

  // Source a: single response beats; source b: requests of one or two beats.
  logic lock_q, own_q, sel, cur_last, acc, w_phase_q;

  assign sel      = lock_q ? own_q : !a_valid;
  assign m_tvalid = sel ? b_valid : a_valid;
  assign m_tdata  = sel ? b_data  : a_data;
  assign m_tuser  = sel ? b_user  : MSG_RSP;
  assign cur_last = sel ? b_last  : 1'b1;
  assign a_ready  = !sel && m_tready;
  assign b_ready  = sel && m_tready;
  assign acc      = m_tvalid && m_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      own_q     <= 1'b0;
      w_phase_q <= 1'b0;
    end else begin
      if (m_tvalid) begin
        lock_q <= !(m_tready && cur_last);
        own_q  <= sel;
      end
      if (acc && m_tuser == MSG_WR) w_phase_q <= !w_phase_q;
    end
  end

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser)); // R12
  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && w_phase_q |-> m_tuser == MSG_WR); // R12

endmodule

// File: rtl/lite_stream_bridge.sv
module lite_stream_bridge
  import lsb_pkg::*;
#(
  parameter int unsigned       SLV_AW    = 15,
  parameter int unsigned       MB_WORDS  = 8,
  parameter logic [31:0]       MBOX_BASE = 32'h0000_2000,
  parameter logic [31:0]       RMT_BASE  = 32'h0000_1000,
  parameter int unsigned       RMT_LG    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  input  logic [31:0]       s_tdata,
  input  logic [1:0]        s_tuser,
  output logic              s_tready,
  output logic              m_tvalid,
  output logic [31:0]       m_tdata,
  output logic [1:0]        m_tuser,
  input  logic              m_tready,
  output logic              mst_awvalid,
  output logic [31:0]       mst_awaddr,
  input  logic              mst_awready,
  output logic              mst_wvalid,
  output logic [31:0]       mst_wdata,
  input  logic              mst_wready,
  input  logic              mst_bvalid,
  output logic              mst_bready,
  output logic              mst_arvalid,
  output logic [31:0]       mst_araddr,
  input  logic              mst_arready,
  input  logic              mst_rvalid,
  input  logic [31:0]       mst_rdata,
  output logic              mst_rready,
  input  logic              slv_awvalid,
  input  logic [SLV_AW-1:0] slv_awaddr,
  output logic              slv_awready,
  input  logic              slv_wvalid,
  input  logic [31:0]       slv_wdata,
  output logic              slv_wready,
  output logic              slv_bvalid,
  output logic [1:0]        slv_bresp,
  input  logic              slv_bready,
  input  logic              slv_arvalid,
  input  logic [SLV_AW-1:0] slv_araddr,
  output logic              slv_arready,
  output logic              slv_rvalid,
  output logic [31:0]       slv_rdata,
  output logic [1:0]        slv_rresp,
  input  logic              slv_rready
);

  localparam int unsigned IW    = $clog2(MB_WORDS);
  localparam int unsigned MB_LG = IW + 2;

  logic          rx_mb_we, tx_mb_we;
  logic [IW-1:0] rx_mb_idx, tx_mb_idx, tx_mb_ridx;
  logic [31:0]   rx_mb_data, tx_mb_data, mb_rdata;
  logic          rsp_hit;
  logic [31:0]   rsp_data;
  logic          rx_up_valid, rx_up_ready, tx_up_valid, tx_up_ready, tx_up_last;
  logic [31:0]   rx_up_data, tx_up_data;
  logic [1:0]    tx_up_user;

  assign slv_bresp = 2'b00;
  assign slv_rresp = 2'b00;

  lsb_mbox #(.DW(WORD_W), .WORDS(MB_WORDS)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .a_we(tx_mb_we), .a_idx(tx_mb_idx), .a_data(tx_mb_data),
    .b_we(rx_mb_we), .b_idx(rx_mb_idx), .b_data(rx_mb_data),
    .r_idx(tx_mb_ridx), .r_data(mb_rdata)
  );

  lsb_rx #(.MB_LG(MB_LG), .MBOX_BASE(MBOX_BASE)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tready(s_tready),
    .mst_awvalid(mst_awvalid), .mst_awaddr(mst_awaddr), .mst_awready(mst_awready),
    .mst_wvalid(mst_wvalid), .mst_wdata(mst_wdata), .mst_wready(mst_wready),
    .mst_bvalid(mst_bvalid), .mst_bready(mst_bready),
    .mst_arvalid(mst_arvalid), .mst_araddr(mst_araddr), .mst_arready(mst_arready),
    .mst_rvalid(mst_rvalid), .mst_rdata(mst_rdata), .mst_rready(mst_rready),
    .mb_we(rx_mb_we), .mb_idx(rx_mb_idx), .mb_data(rx_mb_data),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .up_valid(rx_up_valid), .up_data(rx_up_data), .up_ready(rx_up_ready)
  );

  lsb_tx #(.SLV_AW(SLV_AW), .MB_LG(MB_LG), .MBOX_BASE(MBOX_BASE),
           .RMT_BASE(RMT_BASE), .RMT_LG(RMT_LG)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .slv_awvalid(slv_awvalid), .slv_awaddr(slv_awaddr), .slv_awready(slv_awready),
    .slv_wvalid(slv_wvalid), .slv_wdata(slv_wdata), .slv_wready(slv_wready),
    .slv_bvalid(slv_bvalid), .slv_bready(slv_bready),
    .slv_arvalid(slv_arvalid), .slv_araddr(slv_araddr), .slv_arready(slv_arready),
    .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata), .slv_rready(slv_rready),
    .mb_we(tx_mb_we), .mb_idx(tx_mb_idx), .mb_data(tx_mb_data),
    .mb_ridx(tx_mb_ridx), .mb_rdata(mb_rdata),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .up_valid(tx_up_valid), .up_data(tx_up_data), .up_user(tx_up_user),
    .up_last(tx_up_last), .up_ready(tx_up_ready)
  );

  lsb_up_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .a_valid(rx_up_valid), .a_data(rx_up_data), .a_ready(rx_up_ready),
    .b_valid(tx_up_valid), .b_data(tx_up_data), .b_user(tx_up_user),
    .b_last(tx_up_last), .b_ready(tx_up_ready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tready(m_tready)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !m_tvalid && !slv_bvalid && !slv_rvalid && !mst_awvalid && !mst_arvalid); // R1
  AST_RSP_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_rvalid) |-> $past(slv_arready) || $past(rsp_hit)); // R11

endmodule

// File: tb/lite_stream_bridge_bench.sv
module lite_stream_bridge_bench;

  localparam int unsigned SAW  = 15;
  localparam logic [31:0] KEY  = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        s_tvalid = 0; logic [31:0] s_tdata = 0; logic [1:0] s_tuser = 0; logic s_tready;
  logic        m_tvalid; logic [31:0] m_tdata; logic [1:0] m_tuser; logic m_tready = 1;
  logic        mst_awvalid, mst_wvalid, mst_bready, mst_arvalid, mst_rready;
  logic [31:0] mst_awaddr, mst_wdata, mst_araddr;
  logic [31:0] rd_addr_seen = 0;
  logic [31:0] mst_rdata;
  logic        slv_awvalid = 0, slv_wvalid = 0, slv_bready = 0, slv_arvalid = 0, slv_rready = 0;
  logic [SAW-1:0] slv_awaddr = 0, slv_araddr = 0;
  logic [31:0] slv_wdata = 0, slv_rdata;
  logic        slv_awready, slv_wready, slv_bvalid, slv_arready, slv_rvalid;
  logic [1:0]  slv_bresp, slv_rresp;

  assign mst_rdata = rd_addr_seen ^ KEY;

  lite_stream_bridge u_lite_stream_bridge (
    .clk(clk), .rst_n(rst_n),
    .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tready(s_tready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tready(m_tready),
    .mst_awvalid(mst_awvalid), .mst_awaddr(mst_awaddr), .mst_awready(1'b1),
    .mst_wvalid(mst_wvalid), .mst_wdata(mst_wdata), .mst_wready(1'b1),
    .mst_bvalid(1'b1), .mst_bready(mst_bready),
    .mst_arvalid(mst_arvalid), .mst_araddr(mst_araddr), .mst_arready(1'b1),
    .mst_rvalid(1'b1), .mst_rdata(mst_rdata), .mst_rready(mst_rready),
    .slv_awvalid(slv_awvalid), .slv_awaddr(slv_awaddr), .slv_awready(slv_awready),
    .slv_wvalid(slv_wvalid), .slv_wdata(slv_wdata), .slv_wready(slv_wready),
    .slv_bvalid(slv_bvalid), .slv_bresp(slv_bresp), .slv_bready(slv_bready),
    .slv_arvalid(slv_arvalid), .slv_araddr(slv_araddr), .slv_arready(slv_arready),
    .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata), .slv_rresp(slv_rresp),
    .slv_rready(slv_rready)
  );

  // Monitors: outgoing beats, master writes and reads
  logic [31:0] up_d [64]; logic [1:0] up_u [64]; int up_n = 0;
  logic [31:0] wa_last = 0, wd_last = 0; int wa_n = 0, rd_n = 0;
  initial forever begin
    @(negedge clk);
    if (m_tvalid && m_tready && up_n < 64) begin
      up_d[up_n] = m_tdata; up_u[up_n] = m_tuser; up_n++;
    end
    if (mst_awvalid) begin wa_last = mst_awaddr; wa_n++; end
    if (mst_wvalid)  wd_last = mst_wdata;
    if (mst_arvalid) begin rd_addr_seen = mst_araddr; rd_n++; end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic beat(input logic [1:0] u, input logic [31:0] d);
    s_tvalid = 1; s_tuser = u; s_tdata = d;
    forever begin
      @(negedge clk);
      if (s_tready) begin @(posedge clk); #1; break; end
    end
    s_tvalid = 0;
  endtask

  task automatic slv_aw_w(input logic [SAW-1:0] a, input logic [31:0] d);
    slv_awvalid = 1; slv_wvalid = 1; slv_awaddr = a; slv_wdata = d;
    forever begin
      @(negedge clk);
      if (slv_awready) begin @(posedge clk); #1; break; end
    end
    slv_awvalid = 0; slv_wvalid = 0;
  endtask

  task automatic slv_b(output logic [1:0] resp);
    slv_bready = 1;
    forever begin
      @(negedge clk);
      if (slv_bvalid) begin resp = slv_bresp; @(posedge clk); #1; break; end
    end
    slv_bready = 0;
  endtask

  task automatic slv_write(input logic [SAW-1:0] a, input logic [31:0] d, output logic [1:0] resp);
    slv_aw_w(a, d);
    slv_b(resp);
  endtask

  task automatic slv_read(input logic [SAW-1:0] a, output logic [31:0] d, output logic [1:0] resp);
    slv_arvalid = 1; slv_araddr = a;
    forever begin
      @(negedge clk);
      if (slv_arready) begin @(posedge clk); #1; break; end
    end
    slv_arvalid = 0; slv_rready = 1;
    forever begin
      @(negedge clk);
      if (slv_rvalid) begin d = slv_rdata; resp = slv_rresp; @(posedge clk); #1; break; end
    end
    slv_rready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] r;
    @(negedge clk);
    chk("R1 m_tvalid", 32'(m_tvalid), 0);
    chk("R1 slv_bvalid|rvalid", 32'(slv_bvalid | slv_rvalid), 0);
    chk("R1 mst valids", 32'(mst_awvalid | mst_arvalid | mst_wvalid), 0);
    chk("R1 s_tready", 32'(s_tready), 1);
    idle(1);
    slv_read(15'h00C, d, r);
    chk("R1 mailbox zero", d, 0);
    chk("R1 no beats", 32'(up_n), 0);
  endtask

  task automatic t_ignore;
    int w0 = wa_n, r0 = rd_n, u0 = up_n;
    beat(2'b00, 32'h0000_0500);
    idle(6);
    chk("R2 no master write", 32'(wa_n), 32'(w0));
    chk("R2 no master read", 32'(rd_n), 32'(r0));
    chk("R2 no up beat", 32'(up_n), 32'(u0));
  endtask

  task automatic t_stream_write(input logic [31:0] a, input logic [31:0] d);
    int w0 = wa_n, u0 = up_n;
    beat(2'b01, a);
    beat(2'b11, d);
    idle(8);
    chk("R3 one write", 32'(wa_n), 32'(w0 + 1));
    chk("R3 addr", wa_last, a);
    chk("R3 data", wd_last, d);
    chk("R3 no up beat", 32'(up_n), 32'(u0));
  endtask

  task automatic t_stream_read(input logic [31:0] a);
    int u0 = up_n;
    beat(2'b10, a);
    idle(10);
    chk("R4 one beat", 32'(up_n), 32'(u0 + 1));
    chk("R4 tuser 11", 32'(up_u[u0]), 32'h3);
    chk("R4 data", up_d[u0], a ^ KEY);
  endtask

  task automatic t_mailbox;
    logic [1:0] r; logic [31:0] d; int u0 = up_n;
    m_tready = 0;
    slv_aw_w(15'h014, 32'hDEAD_BEEF);
    idle(6);
    chk("R6 no bvalid before beats", 32'(slv_bvalid), 0);
    m_tready = 1;
    slv_b(r);
    chk("R6 two beats", 32'(up_n), 32'(u0 + 2));
    chk("R6 beat1 addr", up_d[u0], 32'h0000_2014);
    chk("R6 beat1 tuser", 32'(up_u[u0]), 32'h1);
    chk("R6 beat2 data", up_d[u0+1], 32'hDEAD_BEEF);
    chk("R6 beat2 tuser", 32'(up_u[u0+1]), 32'h1);
    slv_read(15'h014, d, r);
    chk("R5 readback", d, 32'hDEAD_BEEF);
    chk("R5 read no beats", 32'(up_n), 32'(u0 + 2));
  endtask

  task automatic t_remote_write;
    logic [1:0] r; int u0 = up_n;
    slv_write(15'h1234, 32'h0BAD_F00D, r);
    chk("R7 bresp", 32'(r), 0);
    chk("R7 two beats", 32'(up_n), 32'(u0 + 2));
    chk("R7 addr", up_d[u0], 32'h0000_1234);
    chk("R7 data", up_d[u0+1], 32'h0BAD_F00D);
    chk("R7 tuser", 32'({up_u[u0], up_u[u0+1]}), 32'h5);
  endtask

  task automatic t_remote_read;
    logic [1:0] r; logic [31:0] d; int u0 = up_n;
    fork
      slv_read(15'h1ABC, d, r);
      begin
        while (up_n == u0) @(negedge clk);
        chk("R8 req tuser 10", 32'(up_u[u0]), 32'h2);
        chk("R8 req addr", up_d[u0], 32'h0000_1ABC);
        repeat (5) @(negedge clk);
        chk("R8 rvalid held low", 32'(slv_rvalid), 0);
        @(posedge clk); #1;
        beat(2'b11, 32'hCAFE_0123);
      end
    join
    chk("R8 rdata", d, 32'hCAFE_0123);
  endtask

  task automatic t_unmapped;
    logic [1:0] r; logic [31:0] d; int u0 = up_n;
    slv_write(15'h0400, 32'h1111_2222, r);
    chk("R9 bresp", 32'(r), 0);
    slv_read(15'h2010, d, r);
    chk("R9 read zero", d, 0);
    chk("R9 rresp", 32'(r), 0);
    chk("R9 no beats", 32'(up_n), 32'(u0));
  endtask

  task automatic t_stream_mbox;
    logic [1:0] r; logic [31:0] d; int w0 = wa_n, u0 = up_n;
    beat(2'b01, 32'h0000_2008);
    beat(2'b01, 32'h7777_1111);
    idle(6);
    chk("R10 no master write", 32'(wa_n), 32'(w0));
    slv_read(15'h008, d, r);
    chk("R10 mailbox updated", d, 32'h7777_1111);
    chk("R10 no echo", 32'(up_n), 32'(u0));
  endtask

  task automatic t_stray_rsp;
    logic [1:0] r; logic [31:0] d; int u0 = up_n;
    beat(2'b11, 32'h4444_4444);
    repeat (4) @(negedge clk);
    chk("R11 no rvalid", 32'(slv_rvalid), 0);
    idle(1);
    slv_read(15'h014, d, r);
    chk("R11 later read intact", d, 32'hDEAD_BEEF);
    chk("R11 no beats", 32'(up_n), 32'(u0));
  endtask

  task automatic t_no_interleave;
    logic [1:0] r; int u0 = up_n;
    m_tready = 0;
    slv_aw_w(15'h1100, 32'hABCD_0001);
    m_tready = 1;
    @(posedge clk); #1;
    m_tready = 0;
    beat(2'b10, 32'h0000_0900);
    idle(8);
    chk("R12 only first beat out", 32'(up_n), 32'(u0 + 1));
    m_tready = 1;
    slv_b(r);
    idle(6);
    chk("R12 three beats", 32'(up_n), 32'(u0 + 3));
    chk("R12 first addr", up_d[u0], 32'h0000_1100);
    chk("R12 data next", up_d[u0+1], 32'hABCD_0001);
    chk("R12 data tuser", 32'(up_u[u0+1]), 32'h1);
    chk("R12 response last", up_d[u0+2], 32'h0000_0900 ^ KEY);
    chk("R12 response tuser", 32'(up_u[u0+2]), 32'h3);
  endtask

  logic done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    idle(1);
    t_reset();
    t_ignore();
    t_stream_write(32'h0000_0440, 32'h1234_5678);
    t_stream_write(32'h0000_7FFC, 32'hFFFF_0000);
    t_stream_read(32'h0000_0880);
    t_mailbox();
    t_remote_write();
    t_remote_read();
    t_unmapped();
    t_stream_mbox();
    t_stray_rsp();
    t_no_interleave();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule